// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is one bank of general-purpose pins with a word-addressed register interface. Each pin can be an input or an output, as chosen by a direction register. Output levels change only through two alias addresses: one sets the bits written as 1 and the other clears them. A plain write of the output value is ignored. Pin levels pass through a two-flop synchronizer and can be read back as a synchronized snapshot.

Each pin can raise an interrupt on a rising edge, a falling edge, a low level or a high level, in any combination. Events latch into a sticky flag register that software clears by writing 1s. A per-pin interrupt enable, changed through separate set and clear addresses, gates both the latching of flags and the single bank interrupt line. A change to any trigger register reaches the detectors only after a fixed settling delay. A small arming state machine enforces this delay. It has two states. It stays in `ARM_RUN` while the trigger setup is steady. A trigger write takes it to `ARM_SETTLE` (transition "cfg write"). Another trigger write in `ARM_SETTLE` restarts the count (transition "restart"). When the count runs out, the new setup is copied to the detectors and the machine returns to `ARM_RUN` (transition "expire"). An integrator who needs several banks creates several instances.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register is all ones (every pin is an input), the output value, interrupt enables, flags and trigger registers are all zero, and `irq` is low.
- R2: Register 0 is the direction register. A 1 bit makes the pin an input and a 0 bit makes it an output. `pad_dir` shows the register, and only a write to register 0 changes it.
- R3: A write to register 3 sets the output bits that are 1 in the data. A write to register 4 clears the output bits that are 1 in the data. Bits written as 0 keep their value. A write to register 2 is ignored. Register 2 reads back the output value, which also drives `pad_out`.
- R4: Register 1 returns the pin levels after a two-flop synchronizer. A level applied to `pad_in` can be read back by a read issued two clock cycles later, and a read issued in the same cycle still returns the old level.
- R5: A write to register 6 sets the interrupt enable bits that are 1 in the data. A write to register 7 clears them. Both registers read back the enable value.
- R6: Register 5 holds the sticky event flags. Writing a 1 clears that flag. Writing back the value that was read clears all reported events.
- R7: Registers 8 and 9 enable rising-edge and falling-edge detection per pin. An edge is found by comparing the current synchronized sample with the previous one. These registers, and registers 10 and 11, read back as written.
- R8: Registers 10 (low level) and 11 (high level) enable level detection. While the level stays active, a cleared flag is set again.
- R9: A flag never sets for a pin whose interrupt enable is clear.
- R10: `irq` is high exactly when some flag is set and its interrupt enable is set. Clearing the enable masks a pending flag without clearing it.
- R11: When a new event and a clear write hit the same flag in the same cycle, the flag stays set.
- R12: A write to any trigger register (8 to 11) takes effect in the detectors `DETECT_DELAY` (default 5) cycles after the write edge. Until then the previous trigger setup stays in force. A further trigger write restarts the delay.
- R13: Read data appears on `bus_rdata` one cycle after the read strobe. Addresses 12 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, registered |
| pad_in | input | W | Pin levels from the pads (asynchronous) |
| pad_out | output | W | Output value to the pads |
| pad_dir | output | W | Direction per pin, 1 = input |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest situation to reach is the race between a level event and a clear write on the same flag in the same cycle. From the ports it looks just like a clear that failed, unless the read that follows is timed exactly. The bench holds a high-level trigger active and issues the clear write and then the flag read back to back. If the clear had won, the flag would still read 0 at that point, because a re-set would not be visible yet. The settling window is checked in a similar way. With the pin already at its trigger level, `irq` is sampled in the cycle just before the new setup may fire and again in the cycle just after.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    // Word addresses of the bank registers
    typedef enum logic [ADDR_W-1:0] {
        REG_DIR        = 4'd0,
        REG_LEVEL_IN   = 4'd1,
        REG_OUT_VAL    = 4'd2,
        REG_OUT_SET    = 4'd3,
        REG_OUT_CLR    = 4'd4,
        REG_EVT_FLAGS  = 4'd5,
        REG_EVT_EN_SET = 4'd6,
        REG_EVT_EN_CLR = 4'd7,
        REG_TRIG_RISE  = 4'd8,
        REG_TRIG_FALL  = 4'd9,
        REG_TRIG_LOW   = 4'd10,
        REG_TRIG_HIGH  = 4'd11
    } reg_sel_e;

    // Arming state of the trigger configuration
    typedef enum logic {
        ARM_RUN    = 1'b0,
        ARM_SETTLE = 1'b1
    } arm_state_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    logic [W-1:0] meta_q;

    // Two-flop synchronizer plus one history stage for edge compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= pad_in;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      level_in,
    input  logic [W-1:0]      flags,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      rise_q,
    output logic [W-1:0]      fall_q,
    output logic [W-1:0]      low_q,
    output logic [W-1:0]      high_q,
    output logic [W-1:0]      flags_clr,
    output logic              cfg_wr
);

    logic          wr_dir, wr_set, wr_clr, wr_flags, wr_en_set, wr_en_clr;
    logic          wr_rise, wr_fall, wr_low, wr_high;
    logic [W-1:0]  rd_mux;

    always_comb begin
        wr_dir    = bus_wr && (bus_addr == REG_DIR);
        wr_set    = bus_wr && (bus_addr == REG_OUT_SET);
        wr_clr    = bus_wr && (bus_addr == REG_OUT_CLR);
        wr_flags  = bus_wr && (bus_addr == REG_EVT_FLAGS);
        wr_en_set = bus_wr && (bus_addr == REG_EVT_EN_SET);
        wr_en_clr = bus_wr && (bus_addr == REG_EVT_EN_CLR);
        wr_rise   = bus_wr && (bus_addr == REG_TRIG_RISE);
        wr_fall   = bus_wr && (bus_addr == REG_TRIG_FALL);
        wr_low    = bus_wr && (bus_addr == REG_TRIG_LOW);
        wr_high   = bus_wr && (bus_addr == REG_TRIG_HIGH);
        cfg_wr    = wr_rise || wr_fall || wr_low || wr_high;
        flags_clr = wr_flags ? bus_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            en_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else begin
            if (wr_dir)    dir_q  <= bus_wdata;
            if (wr_set)    out_q  <= out_q | bus_wdata;
            if (wr_clr)    out_q  <= out_q & ~bus_wdata;
            if (wr_en_set) en_q   <= en_q | bus_wdata;
            if (wr_en_clr) en_q   <= en_q & ~bus_wdata;
            if (wr_rise)   rise_q <= bus_wdata;
            if (wr_fall)   fall_q <= bus_wdata;
            if (wr_low)    low_q  <= bus_wdata;
            if (wr_high)   high_q <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DIR:        rd_mux = dir_q;
            REG_LEVEL_IN:   rd_mux = level_in;
            REG_OUT_VAL,
            REG_OUT_SET,
            REG_OUT_CLR:    rd_mux = out_q;
            REG_EVT_FLAGS:  rd_mux = flags;
            REG_EVT_EN_SET,
            REG_EVT_EN_CLR: rd_mux = en_q;
            REG_TRIG_RISE:  rd_mux = rise_q;
            REG_TRIG_FALL:  rd_mux = fall_q;
            REG_TRIG_LOW:   rd_mux = low_q;
            REG_TRIG_HIGH:  rd_mux = high_q;
            default:        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
    import gpio_bank_pkg::*;
#(
    parameter int W     = 32,
    parameter int DELAY = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [W-1:0]   rise_cfg,
    input  logic [W-1:0]   fall_cfg,
    input  logic [W-1:0]   low_cfg,
    input  logic [W-1:0]   high_cfg,
    input  logic [W-1:0]   lvl,
    input  logic [W-1:0]   lvl_prev,
    input  logic [W-1:0]   en,
    input  logic [W-1:0]   clr,
    output logic [W-1:0]   flags,
    output logic [4*W-1:0] eff_cfg
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(DELAY - 1);

    arm_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          take_cfg;
    logic [W-1:0]  eff_rise, eff_fall, eff_low, eff_high;
    logic [W-1:0]  hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        take_cfg = 1'b0;
        unique case (state_q)
            ARM_RUN: begin
                if (cfg_wr) begin
                    state_d = ARM_SETTLE;
                    cnt_d   = CNT_LOAD;
                end
            end
            ARM_SETTLE: begin
                if (cfg_wr) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    state_d  = ARM_RUN;
                    take_cfg = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_rise <= '0;
            eff_fall <= '0;
            eff_low  <= '0;
            eff_high <= '0;
        end else if (take_cfg) begin
            eff_rise <= rise_cfg;
            eff_fall <= fall_cfg;
            eff_low  <= low_cfg;
            eff_high <= high_cfg;
        end
    end

    assign eff_cfg = {eff_high, eff_low, eff_fall, eff_rise};

    // Per-pin event detection, gated by the interrupt enable
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            hit[i] = en[i] && ((eff_rise[i] &&  lvl[i] && !lvl_prev[i]) ||
                               (eff_fall[i] && !lvl[i] &&  lvl_prev[i]) ||
                               (eff_low[i]  && !lvl[i]) ||
                               (eff_high[i] &&  lvl[i]));
        end

        // New event outranks a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (hit[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W            = 32,
    parameter int DETECT_DELAY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_dir,
    output logic              irq
);

    logic [W-1:0]   lvl, lvl_prev;
    logic [W-1:0]   dir_q, out_q, en_q;
    logic [W-1:0]   rise_q, fall_q, low_q, high_q;
    logic [W-1:0]   flags_q, flags_clr;
    logic           cfg_wr;
    logic [4*W-1:0] eff_cfg;

    gpio_bank_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    gpio_bank_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_in  (lvl),
        .flags     (flags_q),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .en_q      (en_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .low_q     (low_q),
        .high_q    (high_q),
        .flags_clr (flags_clr),
        .cfg_wr    (cfg_wr)
    );

    gpio_bank_detect #(.W(W), .DELAY(DETECT_DELAY)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .rise_cfg (rise_q),
        .fall_cfg (fall_q),
        .low_cfg  (low_q),
        .high_cfg (high_q),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .en       (en_q),
        .clr      (flags_clr),
        .flags    (flags_q),
        .eff_cfg  (eff_cfg)
    );

    assign pad_out = out_q;
    assign pad_dir = dir_q;
    assign irq     = |(flags_q & en_q);

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int W     = 32,
    parameter int DELAY = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_dir,
    input logic              irq,
    input logic [W-1:0]      flags,
    input logic [W-1:0]      en,
    input logic [4*W-1:0]    eff,
    input logic              cfg_wr
);

    localparam int GW = $clog2(DELAY + 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(DELAY);
    localparam logic [GW-1:0] GAP_LAST = GW'(DELAY - 1);

    // Cycles since the last trigger write, saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GAP_MAX;
        else if (cfg_wr)         gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_dir == '1 && pad_out == '0 && !irq));

    assert_dir_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_DIR) |=> $stable(pad_dir));

    assert_out_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OUT_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_out_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OUT_CLR) |=> ((pad_out & $past(bus_wdata)) == '0));

    assert_out_plain_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OUT_VAL) |=> $stable(pad_out));

    assert_flag_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & ~$past(flags) & ~$past(en)) == '0));

    assert_settle_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eff) |-> ($past(gap_q) == GAP_LAST && !$past(cfg_wr)));

    assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > REG_TRIG_HIGH) |=> (bus_rdata == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.W(W), .DELAY(DETECT_DELAY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_dir   (pad_dir),
    .irq       (irq),
    .flags     (flags_q),
    .en        (en_q),
    .eff       (eff_cfg),
    .cfg_wr    (cfg_wr)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    import gpio_bank_pkg::*;

    localparam int W = 32;
    localparam int NV = 22;

    // {read, addr, wdata, expected}
    localparam logic [68:0] VEC [0:NV-1] = '{
        {1'b1, 4'd0,  32'h0,         32'hFFFF_FFFF},
        {1'b1, 4'd2,  32'h0,         32'h0000_0000},
        {1'b0, 4'd3,  32'hA5A5_0F0F, 32'h0},
        {1'b1, 4'd2,  32'h0,         32'hA5A5_0F0F},
        {1'b0, 4'd4,  32'h0000_FFFF, 32'h0},
        {1'b1, 4'd2,  32'h0,         32'hA5A5_0000},
        {1'b0, 4'd2,  32'h1234_5678, 32'h0},
        {1'b1, 4'd2,  32'h0,         32'hA5A5_0000},
        {1'b0, 4'd0,  32'h0000_FFFF, 32'h0},
        {1'b1, 4'd0,  32'h0,         32'h0000_FFFF},
        {1'b0, 4'd6,  32'h0000_00F0, 32'h0},
        {1'b0, 4'd6,  32'h0000_0F00, 32'h0},
        {1'b1, 4'd6,  32'h0,         32'h0000_0FF0},
        {1'b0, 4'd7,  32'h0000_0030, 32'h0},
        {1'b1, 4'd7,  32'h0,         32'h0000_0FC0},
        {1'b0, 4'd7,  32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd6,  32'h0,         32'h0000_0000},
        {1'b0, 4'd8,  32'h0000_1234, 32'h0},
        {1'b1, 4'd8,  32'h0,         32'h0000_1234},
        {1'b0, 4'd8,  32'h0000_0000, 32'h0},
        {1'b1, 4'd15, 32'h0,         32'h0000_0000},
        {1'b1, 4'd1,  32'h0,         32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_dir;
    logic          irq;
    logic [W-1:0]  rv;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    gpio_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_dir   (pad_dir),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0:             return "R2 direction";
            4'd1:             return "R4 level in";
            4'd2, 4'd3, 4'd4: return "R3 output";
            4'd6, 4'd7:       return "R5 enable";
            4'd8, 4'd9:       return "R7 trigger";
            default:          return "R13 unmapped";
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state at the ports
        chk("R1 pad_dir", pad_dir, 32'hFFFF_FFFF);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(4'd5, rv); chk("R1 flags", rv, 32'h0);
        rd(4'd11, rv); chk("R1 trig high", rv, 32'h0);

        // Register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][68]) begin
                rd(VEC[i][67:64], rv);
                chk(req_of(VEC[i][67:64]), rv, VEC[i][31:0]);
            end else begin
                wr(VEC[i][67:64], VEC[i][63:32]);
            end
        end
        chk("R2 pad_dir follows register", pad_dir, 32'h0000_FFFF);
        chk("R3 pad_out follows output value", pad_out, 32'hA5A5_0000);

        // R4 synchronizer latency
        pad_in = 32'h8000_8000;
        rd(4'd1, rv); chk("R4 same-cycle read old", rv, 32'h0);
        pad_in = 32'h8000_8000;
        idle(1);
        rd(4'd1, rv); chk("R4 read after two cycles", rv, 32'h8000_8000);
        pad_in = '0;
        idle(4);

        // R7 rising edge on pin 0, R10 masking
        wr(4'd6, 32'h1);
        wr(4'd8, 32'h1);
        idle(8);
        pad_in[0] = 1'b1;
        idle(4);
        rd(4'd5, rv); chk("R7 rising edge flag", rv, 32'h1);
        chk("R10 irq on enabled flag", {31'b0, irq}, 32'h1);
        wr(4'd7, 32'h1);
        chk("R10 irq masked by enable", {31'b0, irq}, 32'h0);
        rd(4'd5, rv); chk("R10 flag kept when masked", rv, 32'h1);
        wr(4'd6, 32'h1);
        chk("R10 irq back on", {31'b0, irq}, 32'h1);
        rd(4'd5, rv);
        wr(4'd5, rv);
        rd(4'd5, rv); chk("R6 write-back clears", rv, 32'h0);
        chk("R6 irq low after clear", {31'b0, irq}, 32'h0);

        // R7 falling edge on pin 1
        wr(4'd6, 32'h2);
        wr(4'd9, 32'h2);
        idle(8);
        pad_in[1] = 1'b1;
        idle(4);
        rd(4'd5, rv); chk("R7 rise ignored by fall trigger", rv, 32'h0);
        pad_in[1] = 1'b0;
        idle(4);
        rd(4'd5, rv); chk("R7 falling edge flag", rv, 32'h2);
        wr(4'd5, 32'h2);

        // R9 trigger enabled, interrupt enable clear on pin 2
        wr(4'd8, 32'h5);
        idle(8);
        pad_in[2] = 1'b1;
        idle(4);
        rd(4'd5, rv); chk("R9 no flag without enable", rv, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);

        // R8 and R11 high level on pin 3
        wr(4'd6, 32'h8);
        wr(4'd11, 32'h8);
        idle(8);
        pad_in[3] = 1'b1;
        idle(4);
        rd(4'd5, rv); chk("R8 high level flag", rv, 32'h8);
        wr(4'd5, 32'h8);
        chk("R11 irq held through clear", {31'b0, irq}, 32'h1);
        rd(4'd5, rv); chk("R11 set wins over clear", rv, 32'h8);
        idle(3);
        rd(4'd5, rv); chk("R8 level re-sets flag", rv, 32'h8);
        pad_in[3] = 1'b0;
        idle(4);
        wr(4'd5, 32'h8);
        rd(4'd5, rv); chk("R8 flag stays clear when level gone", rv, 32'h0);

        // R12 settling delay on pin 4
        wr(4'd6, 32'h10);
        pad_in[4] = 1'b1;
        idle(4);
        wr(4'd11, 32'h10);
        idle(5);
        chk("R12 no event before delay", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R12 event after delay", {31'b0, irq}, 32'h1);

        summary();
        $finish;
    end

endmodule